// File: doc/BRIEF.md
# Coarse-Grained Thread Switch Controller

This block steers a block-interleaved multithreaded pipeline. It holds a small, fixed set of hardware thread contexts and lets exactly one of them issue until a switch event happens. It then picks another thread that is able to run. The possible events are these:
- a switch instruction whose predicate is true;
- an external interrupt-like request;
- a cache miss reported by a later pipeline stage for the running thread;
- in the lazy mode, a decoded instruction that reads a register whose load data has not yet come back.

On every switch the controller asks the pipeline to squash the outgoing thread's younger in-flight work. That thread resumes later from its saved fetch address.

Each thread has one valid bit per architectural register. Issuing a load clears the bit for its destination, and the returning fill sets it again. A thread that switched away is held not-ready until the fill it waits for arrives. A static mode input chooses the policy. In switch-on-miss mode a miss blocks the thread and any fill for it releases it. In switch-on-use mode a miss is ignored, and the thread only gives way when it actually consumes a missing value. When no thread can run, the controller raises a stall and holds the current thread number until a fill frees one.

Top module: `blockThreadSwitcher`

## Requirements
- R1: After reset the active thread is 0, flush and stall are low, every register valid bit is set and every thread is ready.
- R2: A decoded switch instruction (decValid, decSwitch) with decSwitchTaken high causes a switch. On the next cycle flush is high, flushThread holds the old thread and activeThread holds the newly picked one. With decSwitchTaken low nothing changes.
- R3: extReq high in a cycle without stall causes a switch in the same way. extReq is ignored while stalled.
- R4: In switch-on-miss mode (useMode=0), missValid for the active thread causes a switch. A miss for any thread marks that thread not ready until the next fill for that thread. A miss for a thread that is not active causes no switch.
- R5: A load accepted from decode clears the valid bit of decLoadDst for the active thread, and a fill sets the bit of fillReg for fillThread. A load whose instruction is itself squashed by a switch in the same cycle clears nothing. In switch-on-use mode (useMode=1), missValid neither switches nor blocks.
- R6: In switch-on-use mode, an accepted instruction that reads an enabled source whose valid bit is clear causes a switch. The thread then stays not ready until a fill arrives for that register. A fill for another register does not release it.
- R7: A fill for the active thread's register in the same cycle as a read of that register counts as valid, so no switch occurs.
- R8: The new thread is the first ready thread in the order current+1, current+2, and so on (wrapping), ending with the current thread itself.
- R9: If a switch finds no ready thread, stall rises on the next cycle and activeThread is held. In the first stalled cycle in which a thread becomes ready, stall falls on the next edge and activeThread takes the first ready thread in R8 order, without a flush.
- R10: Decode inputs are ignored in the cycle when flush is high and while stalled.
- R11: flush is high for exactly one cycle per switch event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| useMode | input | 1 | 0: switch on miss, 1: switch on use |
| decValid | input | 1 | An instruction of the active thread is in decode |
| decSrcA | input | RW | First source register |
| decSrcAEn | input | 1 | First source is read |
| decSrcB | input | RW | Second source register |
| decSrcBEn | input | 1 | Second source is read |
| decLoad | input | 1 | Instruction is a load |
| decLoadDst | input | RW | Load destination register |
| decSwitch | input | 1 | Instruction is a switch instruction |
| decSwitchTaken | input | 1 | Predicate of the switch instruction is true |
| extReq | input | 1 | External switch request |
| missValid | input | 1 | A later stage reports a cache miss |
| missThread | input | TW | Thread of the miss |
| fillValid | input | 1 | Load data returns |
| fillThread | input | TW | Thread of the returning load |
| fillReg | input | RW | Destination register of the returning load |
| activeThread | output | TW | Thread allowed to issue |
| flush | output | 1 | Squash the younger work of flushThread |
| flushThread | output | TW | Outgoing thread to squash |
| stall | output | 1 | No thread is ready |

## Verification
Two functions can meet in one cycle. The first is the fill path that sets a valid bit or releases a blocked thread. The second is the event path that decides whether to switch and where to go. The bench provokes the overlap twice. It drives a read of a pending register together with its fill and expects no switch. It drives an external request together with a fill that frees the only ready candidate and expects the freed thread to be picked. A further case pairs a load with a source read that forces a switch. The bench then later reads the load's destination to confirm that its valid bit was never cleared.

// File: rtl/tswPkg.sv
package tswPkg;

  typedef enum logic {
    MODE_ON_MISS = 1'b0,
    MODE_ON_USE  = 1'b1
  } tswMode_e;

  // strobes from the switch control into the context state
  typedef struct packed {
    logic clrLoad;    // accepted load clears its destination valid bit
    logic blockUse;   // active thread waits for the register it consumed
    logic blockMiss;  // miss thread waits for any fill
  } tswStrobes_t;

endpackage

// File: rtl/tswContextState.sv
module tswContextState
  import tswPkg::*;
#(
  parameter int NTHREAD = 4,
  parameter int NREG    = 16,
  localparam int TW = $clog2(NTHREAD),
  localparam int RW = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TW-1:0]      activeThread,
  input  logic [RW-1:0]      decSrcA,
  input  logic               decSrcAEn,
  input  logic [RW-1:0]      decSrcB,
  input  logic               decSrcBEn,
  input  logic [RW-1:0]      decLoadDst,
  input  logic [TW-1:0]      missThread,
  input  logic               fillValid,
  input  logic [TW-1:0]      fillThread,
  input  logic [RW-1:0]      fillReg,
  input  tswStrobes_t        strobes,
  output logic               useHit,
  output logic [NTHREAD-1:0] readyNext
);

  logic [NTHREAD-1:0][NREG-1:0] validVec;
  logic [NREG-1:0] activeValid;
  logic fillActive;
  logic aBad;
  logic bBad;
  logic [RW-1:0] useReg;

  assign activeValid = validVec[activeThread];
  assign fillActive  = fillValid && (fillThread == activeThread);

  // a fill in the same cycle as the read counts as valid (R7)
  assign aBad = decSrcAEn && !activeValid[decSrcA] && !(fillActive && fillReg == decSrcA);
  assign bBad = decSrcBEn && !activeValid[decSrcB] && !(fillActive && fillReg == decSrcB);
  assign useHit = aBad || bBad;
  assign useReg = aBad ? decSrcA : decSrcB;

  for (genvar t = 0; t < NTHREAD; t++) begin : gCtx
    logic [NREG-1:0] validQ;
    logic            blockedQ;
    logic            blockedD;
    logic            waitMissQ;
    logic            waitMissD;
    logic [RW-1:0]   waitRegQ;
    logic [RW-1:0]   waitRegD;
    logic            fillMine;
    logic            isActive;

    assign fillMine = fillValid && (fillThread == TW'(t));
    assign isActive = (activeThread == TW'(t));

    always_comb begin
      blockedD  = blockedQ;
      waitMissD = waitMissQ;
      waitRegD  = waitRegQ;
      if (blockedQ && fillMine && (waitMissQ || fillReg == waitRegQ)) begin
        blockedD = 1'b0;
      end
      if (strobes.blockMiss && missThread == TW'(t)) begin
        blockedD  = 1'b1;
        waitMissD = 1'b1;
      end
      if (strobes.blockUse && isActive) begin
        blockedD  = 1'b1;
        waitMissD = 1'b0;
        waitRegD  = useReg;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ    <= '1;
        blockedQ  <= 1'b0;
        waitMissQ <= 1'b0;
        waitRegQ  <= '0;
      end else begin
        if (fillMine) begin
          validQ[fillReg] <= 1'b1;
        end
        // a new load to the same register wins over an older fill
        if (strobes.clrLoad && isActive) begin
          validQ[decLoadDst] <= 1'b0;
        end
        blockedQ  <= blockedD;
        waitMissQ <= waitMissD;
        waitRegQ  <= waitRegD;
      end
    end

    assign validVec[t]  = validQ;
    assign readyNext[t] = !blockedD;
  end

endmodule

// File: rtl/tswSwitchFsm.sv
module tswSwitchFsm
  import tswPkg::*;
#(
  parameter int NTHREAD = 4,
  localparam int TW = $clog2(NTHREAD)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               useMode,
  input  logic               decValid,
  input  logic               decLoad,
  input  logic               decSwitch,
  input  logic               decSwitchTaken,
  input  logic               extReq,
  input  logic               missValid,
  input  logic [TW-1:0]      missThread,
  input  logic               useHit,
  input  logic [NTHREAD-1:0] readyNext,
  output tswStrobes_t        strobes,
  output logic [TW-1:0]      activeThread,
  output logic               flush,
  output logic [TW-1:0]      flushThread,
  output logic               stall
);

  tswMode_e      mode;
  logic [TW-1:0] activeQ;
  logic [TW-1:0] flushThreadQ;
  logic          flushQ;
  logic          stallQ;
  logic          accept;
  logic          useEv;
  logic          explicitEv;
  logic          missEv;
  logic          extEv;
  logic          switchEv;
  logic          found;
  logic [TW-1:0] pick;
  logic [TW-1:0] cand;

  assign mode = tswMode_e'(useMode);

  // decode belongs to squashed work during flush and is idle while stalled
  assign accept     = decValid && !stallQ && !flushQ;
  assign useEv      = (mode == MODE_ON_USE) && accept && useHit;
  assign explicitEv = accept && decSwitch && decSwitchTaken;
  assign missEv     = (mode == MODE_ON_MISS) && missValid && (missThread == activeQ) && !stallQ;
  assign extEv      = extReq && !stallQ;
  assign switchEv   = useEv || explicitEv || missEv || extEv;

  assign strobes.clrLoad   = accept && decLoad && !switchEv;
  assign strobes.blockUse  = useEv;
  assign strobes.blockMiss = (mode == MODE_ON_MISS) && missValid;

  // round-robin: lowest offset from the current thread wins, current last
  always_comb begin
    found = 1'b0;
    pick  = activeQ;
    cand  = activeQ;
    for (int off = NTHREAD; off >= 1; off--) begin
      cand = activeQ + TW'(off);
      if (readyNext[cand]) begin
        found = 1'b1;
        pick  = cand;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ      <= '0;
      flushQ       <= 1'b0;
      flushThreadQ <= '0;
      stallQ       <= 1'b0;
    end else if (stallQ) begin
      flushQ <= 1'b0;
      if (found) begin
        stallQ  <= 1'b0;
        activeQ <= pick;
      end
    end else if (switchEv) begin
      flushQ       <= 1'b1;
      flushThreadQ <= activeQ;
      if (found) begin
        activeQ <= pick;
      end else begin
        stallQ <= 1'b1;
      end
    end else begin
      flushQ <= 1'b0;
    end
  end

  assign activeThread = activeQ;
  assign flush        = flushQ;
  assign flushThread  = flushThreadQ;
  assign stall        = stallQ;

endmodule

// File: rtl/blockThreadSwitcher.sv
module blockThreadSwitcher
  import tswPkg::*;
#(
  parameter int NTHREAD = 4,
  parameter int NREG    = 16,
  localparam int TW = $clog2(NTHREAD),
  localparam int RW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          useMode,
  input  logic          decValid,
  input  logic [RW-1:0] decSrcA,
  input  logic          decSrcAEn,
  input  logic [RW-1:0] decSrcB,
  input  logic          decSrcBEn,
  input  logic          decLoad,
  input  logic [RW-1:0] decLoadDst,
  input  logic          decSwitch,
  input  logic          decSwitchTaken,
  input  logic          extReq,
  input  logic          missValid,
  input  logic [TW-1:0] missThread,
  input  logic          fillValid,
  input  logic [TW-1:0] fillThread,
  input  logic [RW-1:0] fillReg,
  output logic [TW-1:0] activeThread,
  output logic          flush,
  output logic [TW-1:0] flushThread,
  output logic          stall
);

  tswStrobes_t        strobes;
  logic               useHit;
  logic [NTHREAD-1:0] readyNext;

  tswSwitchFsm #(.NTHREAD(NTHREAD)) u_ctl (
    .clk            (clk),
    .rstN           (rstN),
    .useMode        (useMode),
    .decValid       (decValid),
    .decLoad        (decLoad),
    .decSwitch      (decSwitch),
    .decSwitchTaken (decSwitchTaken),
    .extReq         (extReq),
    .missValid      (missValid),
    .missThread     (missThread),
    .useHit         (useHit),
    .readyNext      (readyNext),
    .strobes        (strobes),
    .activeThread   (activeThread),
    .flush          (flush),
    .flushThread    (flushThread),
    .stall          (stall)
  );

  tswContextState #(.NTHREAD(NTHREAD), .NREG(NREG)) u_ctx (
    .clk          (clk),
    .rstN         (rstN),
    .activeThread (activeThread),
    .decSrcA      (decSrcA),
    .decSrcAEn    (decSrcAEn),
    .decSrcB      (decSrcB),
    .decSrcBEn    (decSrcBEn),
    .decLoadDst   (decLoadDst),
    .missThread   (missThread),
    .fillValid    (fillValid),
    .fillThread   (fillThread),
    .fillReg      (fillReg),
    .strobes      (strobes),
    .useHit       (useHit),
    .readyNext    (readyNext)
  );

endmodule

// File: rtl/tswSwitchChecker.sv
module tswSwitchChecker #(
  parameter int NTHREAD = 4,
  localparam int TW = $clog2(NTHREAD)
) (
  input logic          clk,
  input logic          rstN,
  input logic          decValid,
  input logic          decSwitch,
  input logic          decSwitchTaken,
  input logic          extReq,
  input logic          missValid,
  input logic [TW-1:0] activeThread,
  input logic          flush,
  input logic [TW-1:0] flushThread,
  input logic          stall
);

  p_explicit_switch_r2: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && decSwitch && decSwitchTaken && !stall && !flush) |=> flush);

  p_ext_switch_r3: assert property (@(posedge clk) disable iff (!rstN)
    (extReq && !stall) |=> flush);

  p_stall_holds_thread_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stall && $past(stall)) |-> (activeThread == $past(activeThread)));

  p_no_flush_in_stall_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stall && $past(stall)) |-> !flush);

  p_quiet_no_flush_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!extReq && !missValid && (stall || flush || !decValid)) |=> !flush);

  p_flush_names_old_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flush) |-> (flushThread == $past(activeThread)));

  p_change_needs_flush_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && !$past(stall) && activeThread != $past(activeThread)) |-> flush);

endmodule

bind blockThreadSwitcher tswSwitchChecker #(.NTHREAD(NTHREAD)) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .decValid       (decValid),
  .decSwitch      (decSwitch),
  .decSwitchTaken (decSwitchTaken),
  .extReq         (extReq),
  .missValid      (missValid),
  .activeThread   (activeThread),
  .flush          (flush),
  .flushThread    (flushThread),
  .stall          (stall)
);

// File: tb/blockThreadSwitcher_bench.sv
module blockThreadSwitcher_bench;

  localparam int NTHREAD = 4;
  localparam int NREG    = 16;
  localparam int TW = $clog2(NTHREAD);
  localparam int RW = $clog2(NREG);

  logic          clk = 1'b0;
  logic          rstN;
  logic          useMode;
  logic          decValid;
  logic [RW-1:0] decSrcA;
  logic          decSrcAEn;
  logic [RW-1:0] decSrcB;
  logic          decSrcBEn;
  logic          decLoad;
  logic [RW-1:0] decLoadDst;
  logic          decSwitch;
  logic          decSwitchTaken;
  logic          extReq;
  logic          missValid;
  logic [TW-1:0] missThread;
  logic          fillValid;
  logic [TW-1:0] fillThread;
  logic [RW-1:0] fillReg;
  logic [TW-1:0] activeThread;
  logic          flush;
  logic [TW-1:0] flushThread;
  logic          stall;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    int    act;
    bit    fl;
    int    ft;
    bit    st;
    string tag;
  } expItem_t;

  expItem_t expQ[$];

  always #5 clk = ~clk;

  blockThreadSwitcher #(.NTHREAD(NTHREAD), .NREG(NREG)) u_blockThreadSwitcher (
    .clk(clk), .rstN(rstN), .useMode(useMode),
    .decValid(decValid), .decSrcA(decSrcA), .decSrcAEn(decSrcAEn),
    .decSrcB(decSrcB), .decSrcBEn(decSrcBEn), .decLoad(decLoad),
    .decLoadDst(decLoadDst), .decSwitch(decSwitch), .decSwitchTaken(decSwitchTaken),
    .extReq(extReq), .missValid(missValid), .missThread(missThread),
    .fillValid(fillValid), .fillThread(fillThread), .fillReg(fillReg),
    .activeThread(activeThread), .flush(flush), .flushThread(flushThread), .stall(stall)
  );

  task automatic compare(input expItem_t e);
    checks++;
    if (int'(activeThread) != e.act || flush !== e.fl || stall !== e.st ||
        (e.fl && int'(flushThread) != e.ft)) begin
      errors++;
      $display("FAIL %s: act=%0d flush=%0b fthr=%0d stall=%0b expected act=%0d flush=%0b fthr=%0d stall=%0b",
               e.tag, activeThread, flush, flushThread, stall, e.act, e.fl, e.ft, e.st);
    end
  endtask

  // monitor: one expectation per cycle, compared away from the active edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      compare(expQ.pop_front());
    end
  end

  task automatic idleInputs();
    decValid = 0; decSrcA = '0; decSrcAEn = 0; decSrcB = '0; decSrcBEn = 0;
    decLoad = 0; decLoadDst = '0; decSwitch = 0; decSwitchTaken = 0;
    extReq = 0; missValid = 0; missThread = '0;
    fillValid = 0; fillThread = '0; fillReg = '0;
  endtask

  // driver: inputs already set; after the edge push what must appear
  task automatic tick(input int act, input bit fl, input int ft, input bit st, input string tag);
    expItem_t e;
    @(posedge clk);
    e.act = act; e.fl = fl; e.ft = ft; e.st = st; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
    idleInputs();
  endtask

  task automatic doReset();
    expItem_t e;
    rstN = 0;
    idleInputs();
    repeat (2) @(posedge clk);
    @(negedge clk);
    e.act = 0; e.fl = 0; e.ft = 0; e.st = 0; e.tag = "R1 in reset";
    compare(e);
    rstN = 1;
    tick(0, 0, 0, 0, "R1 after reset");
  endtask

  task automatic swInstr(input bit taken);
    decValid = 1; decSwitch = 1; decSwitchTaken = taken;
  endtask

  task automatic readSrc(input int a);
    decValid = 1; decSrcAEn = 1; decSrcA = RW'(a);
  endtask

  task automatic fill(input int thr, input int r);
    fillValid = 1; fillThread = TW'(thr); fillReg = RW'(r);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // ---------------- switch-on-miss mode ----------------
    useMode = 0;
    doReset();
    tick(0, 0, 0, 0, "R1 idle");
    swInstr(0);                tick(0, 0, 0, 0, "R2 predicate false");
    swInstr(1);                tick(1, 1, 0, 0, "R2 switch taken");
    tick(1, 0, 0, 0, "R11 flush one cycle");
    extReq = 1;                tick(2, 1, 1, 0, "R3 external request");
    swInstr(1);                tick(2, 0, 0, 0, "R10 decode ignored in flush");
    missValid = 1; missThread = 2;
    tick(3, 1, 2, 0, "R4 miss on active");
    missValid = 1; missThread = 0;
    tick(3, 0, 0, 0, "R4 miss on other no switch");
    swInstr(1);                tick(1, 1, 3, 0, "R8 skip blocked thread 0");
    tick(1, 0, 0, 0, "R11 idle");
    missValid = 1; missThread = 1;
    tick(3, 1, 1, 0, "R8 skip blocked thread 2");
    tick(3, 0, 0, 0, "R11 idle");
    missValid = 1; missThread = 3;
    tick(3, 1, 3, 1, "R9 no ready thread stalls");
    swInstr(1); extReq = 1;    tick(3, 0, 0, 1, "R10 R3 ignored while stalled");
    fill(1, 4);                tick(1, 0, 0, 0, "R9 release to thread 1");
    fill(0, 2); extReq = 1;    tick(0, 1, 1, 0, "R4 fill frees thread 0 with ext");
    tick(0, 0, 0, 0, "R11 idle");
    fill(2, 0);                tick(0, 0, 0, 0, "R4 fill thread 2");
    fill(3, 0);                tick(0, 0, 0, 0, "R4 fill thread 3");
    extReq = 1;                tick(1, 1, 0, 0, "R8 all ready goes to next");
    tick(1, 0, 0, 0, "R11 idle");

    // ---------------- switch-on-use mode ----------------
    useMode = 1;
    doReset();
    decValid = 1; decLoad = 1; decLoadDst = 5;
    tick(0, 0, 0, 0, "R5 load issue no switch");
    readSrc(6);                tick(0, 0, 0, 0, "R6 valid source no switch");
    missValid = 1; missThread = 0;
    tick(0, 0, 0, 0, "R5 miss ignored in use mode");
    decValid = 1; decSrcBEn = 1; decSrcB = 5;
    tick(1, 1, 0, 0, "R6 read of pending register");
    tick(1, 0, 0, 0, "R11 idle");
    swInstr(1);                tick(2, 1, 1, 0, "R8 to 2");
    tick(2, 0, 0, 0, "R11 idle");
    swInstr(1);                tick(3, 1, 2, 0, "R8 to 3");
    tick(3, 0, 0, 0, "R11 idle");
    fill(0, 7); swInstr(1);    tick(1, 1, 3, 0, "R6 other register fill keeps block");
    tick(1, 0, 0, 0, "R11 idle");
    fill(0, 5);                tick(1, 0, 0, 0, "R5 fill of waited register");
    swInstr(1);                tick(2, 1, 1, 0, "R8 to 2 again");
    tick(2, 0, 0, 0, "R11 idle");
    swInstr(1);                tick(3, 1, 2, 0, "R8 to 3 again");
    tick(3, 0, 0, 0, "R11 idle");
    swInstr(1);                tick(0, 1, 3, 0, "R6 thread 0 released");
    tick(0, 0, 0, 0, "R11 idle");
    decValid = 1; decLoad = 1; decLoadDst = 9;
    tick(0, 0, 0, 0, "R5 load r9");
    readSrc(9); fill(0, 9);    tick(0, 0, 0, 0, "R7 same-cycle fill bypass");
    decValid = 1; decLoad = 1; decLoadDst = 11;
    tick(0, 0, 0, 0, "R5 load r11");
    readSrc(11); decLoad = 1; decLoadDst = 12;
    tick(1, 1, 0, 0, "R6 switch on r11");
    tick(1, 0, 0, 0, "R11 idle");
    fill(0, 11); extReq = 1;   tick(2, 1, 1, 0, "R3 ext to 2");
    tick(2, 0, 0, 0, "R11 idle");
    extReq = 1;                tick(3, 1, 2, 0, "R3 ext to 3");
    tick(3, 0, 0, 0, "R11 idle");
    extReq = 1;                tick(0, 1, 3, 0, "R8 back to 0");
    tick(0, 0, 0, 0, "R11 idle");
    readSrc(12);               tick(0, 0, 0, 0, "R5 squashed load left r12 valid");
    readSrc(11);               tick(0, 0, 0, 0, "R5 fill set r11 valid");

    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule